// File: doc/BRIEF.md
# I2C Target Front End with General-Call Reset

This block is the two-wire serial bus target for a small register-mapped peripheral. It samples the bus clock and data lines with the system clock. It finds start, repeated-start and stop conditions, and it compares the first byte of each transfer with a seven-bit device address. Six bits of that address are fixed by a parameter, and the lowest bit comes from an external strap pin. The block never drives the bus clock. On the data line it only pulls low, through an enable output, and the pad driver sits outside the block.

In a write transfer, the first data byte loads an internal register pointer. Each later byte is handed to a simple register-file port with a one-cycle write strobe, and the pointer then advances. In a read transfer, the block fetches a byte from the register-file port at the pointer and shifts it out MSB first. It keeps going for as long as the controller acknowledges.

The block also accepts the general-call address 0x00. When the general-call command byte is 0x06, the block raises a one-cycle software reset pulse to the rest of the device. The pulse comes on the rising bus-clock edge of the acknowledge clock that follows the 0x06 byte.

Top module: `i2c_target_gcr`

## Requirements
- R1: After reset, sda_pull_o, reg_wr_o, reg_rd_o and soft_rst_o are all 0.
- R2: The device address is {ADDR_PREFIX, addr_pin_i}, sent in the upper seven bits of the first byte, with bit 0 as the read flag (1 = read). On a match, sda_pull_o is 1 through the whole ninth clock. Any other first byte is not acknowledged, and the data line stays released until the next start or stop. This includes a byte whose upper five bits are 11110.
- R3: In a write transfer, the first data byte sets the pointer. Each later byte gives one reg_wr_o pulse with reg_addr_o equal to the pointer and reg_wdata_o equal to the byte, and the pointer then advances by one. Every data byte is acknowledged.
- R4: In a read transfer, each byte is fetched from reg_rdata_i in the cycle that reg_rd_o is 1. reg_addr_o is the pointer in that cycle, and the pointer then advances by one. Each byte is driven MSB first, and a controller acknowledge (data low) continues the transfer with the next byte.
- R5: After a controller not-acknowledge (data high) on a read byte, the data line stays released for any further clocks until the next start or stop.
- R6: A general call is address byte 0x00 followed by command byte 0x06. Both bytes are acknowledged. soft_rst_o pulses for exactly one system-clock cycle, three system clocks after the bus clock rises for the acknowledge clock of the 0x06 byte. A different command byte is not acknowledged and gives no pulse.
- R7: A repeated start is accepted in the middle of a transfer and begins a new address phase. The pointer is kept across the repeated start.
- R8: sda_pull_o changes only while the synchronised bus clock is low. After a stop, sda_pull_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16 times the bus bit rate |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock as seen at the pad |
| sda_i | input | 1 | Bus data as seen at the pad |
| addr_pin_i | input | 1 | Strap pin giving the address LSB |
| sda_pull_o | output | 1 | 1 = pad pulls the data line low |
| reg_wr_o | output | 1 | One-cycle register write strobe |
| reg_rd_o | output | 1 | One-cycle register fetch strobe; reg_rdata_i is sampled in this cycle |
| reg_addr_o | output | 8 | Register pointer |
| reg_wdata_o | output | 8 | Register write data |
| reg_rdata_i | input | 8 | Register read data, combinational from reg_addr_o |
| soft_rst_o | output | 1 | One-cycle software reset pulse |

## Verification
The hardest case to reach from the ports is the placement of the software reset. The pulse must appear on the acknowledge clock of the second general-call byte, not on a data bit, and must not follow a different command byte. The bench records the system-clock cycle in which it raises the bus clock for each acknowledge. A monitor stamps the cycle of every reset pulse, so the bench can compare the two cycle numbers. The not-acknowledge release is reached by clocking one extra bit after a refused read byte and reading the line level.

// File: rtl/i2c_tgt_pkg.sv
`timescale 1ns/1ps
// Package: shared constants and the state type of the bus target.
// Assumes byte-wide transfers and a byte-wide register pointer.
package i2c_tgt_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W + 2);
    localparam logic [BYTE_W-1:0] GC_ADDR_BYTE = 8'h00;
    localparam logic [BYTE_W-1:0] GC_RST_CMD   = 8'h06;
    localparam logic [4:0]        TENBIT_HDR   = 5'b11110;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_WR,
        ST_RD,
        ST_GC,
        ST_SKIP
    } tgt_state_e;
endpackage

// File: rtl/i2c_tgt_sync.sv
`timescale 1ns/1ps
// Synchroniser: passes each raw bus line through a flop chain and
// reports its settled level plus one-cycle rise and fall events.
// Assumes lines idle high, so the chain resets to 1. STAGES >= 2.
module i2c_tgt_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw_i,
    output logic [WIDTH-1:0] lvl_o,
    output logic [WIDTH-1:0] rise_o,
    output logic [WIDTH-1:0] fall_o
);
    for (genvar g = 0; g < WIDTH; g++) begin : g_line
        logic [STAGES-1:0] chain;
        logic              prev;

        // Shift the raw line through the chain and keep the last level.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chain <= '1;
                prev  <= 1'b1;
            end else begin
                chain <= {chain[STAGES-2:0], raw_i[g]};
                prev  <= chain[STAGES-1];
            end
        end

        assign lvl_o[g]  = chain[STAGES-1];
        assign rise_o[g] = chain[STAGES-1] & ~prev;
        assign fall_o[g] = ~chain[STAGES-1] & prev;
    end
endmodule

// File: rtl/i2c_tgt_cond.sv
`timescale 1ns/1ps
// Condition detector: flags a start (data falls while the clock is
// high) and a stop (data rises while the clock is high).
// Assumes synchronised inputs; a repeated start looks the same as a start.
module i2c_tgt_cond (
    input  logic scl_lvl,
    input  logic sda_rise,
    input  logic sda_fall,
    output logic start_o,
    output logic stop_o
);
    // Combine the data edges with the clock level.
    always_comb begin
        start_o = sda_fall & scl_lvl;
        stop_o  = sda_rise & scl_lvl;
    end
endmodule

// File: rtl/i2c_tgt_engine.sv
`timescale 1ns/1ps
// Byte engine: counts bits, shifts data in and out, decides the
// acknowledge, drives the register port and decodes the general-call
// reset. Assumes one-cycle clock edge events from the synchroniser and
// at least a few system clocks between bus clock edges.
module i2c_tgt_engine
    import i2c_tgt_pkg::*;
#(
    parameter logic [5:0] ADDR_PREFIX = 6'b100110
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda_lvl,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              addr_pin,
    input  logic [BYTE_W-1:0] reg_rdata,
    output logic              sda_pull,
    output logic              reg_wr,
    output logic              reg_rd,
    output logic [BYTE_W-1:0] reg_addr,
    output logic [BYTE_W-1:0] reg_wdata,
    output logic              soft_rst
);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] ACK_BIT  = CNT_W'(BYTE_W + 1);

    tgt_state_e        state, next_st;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] rx_sh, tx_sh, ptr;
    logic              ptr_valid, wr_done, gc_hit;
    logic              active, own_match, load_rd;

    // Decode whether the engine is taking part and whether a fetch happens now.
    always_comb begin
        active    = (state != ST_IDLE) && (state != ST_SKIP);
        own_match = (rx_sh[BYTE_W-1:1] == {ADDR_PREFIX, addr_pin}) &&
                    (rx_sh[BYTE_W-1:BYTE_W-5] != TENBIT_HDR);
        load_rd   = active && !start_det && !stop_det && scl_fall &&
                    (bit_cnt == ACK_BIT) && (next_st == ST_RD);
    end

    assign reg_rd   = load_rd;
    assign reg_addr = ptr;

    // Bus protocol sequencing, one event per system clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            next_st   <= ST_IDLE;
            bit_cnt   <= '0;
            rx_sh     <= '0;
            tx_sh     <= '0;
            ptr       <= '0;
            ptr_valid <= 1'b0;
            wr_done   <= 1'b0;
            gc_hit    <= 1'b0;
            sda_pull  <= 1'b0;
            reg_wr    <= 1'b0;
            reg_wdata <= '0;
            soft_rst  <= 1'b0;
        end else begin
            reg_wr   <= 1'b0;
            soft_rst <= 1'b0;
            if (start_det) begin
                state     <= ST_ADDR;
                bit_cnt   <= '0;
                sda_pull  <= 1'b0;
                ptr_valid <= 1'b0;
                wr_done   <= 1'b0;
                gc_hit    <= 1'b0;
            end else if (stop_det) begin
                state    <= ST_IDLE;
                bit_cnt  <= '0;
                sda_pull <= 1'b0;
                wr_done  <= 1'b0;
            end else if (active && scl_rise) begin
                if (bit_cnt < LAST_BIT) begin
                    rx_sh   <= {rx_sh[BYTE_W-2:0], sda_lvl};
                    bit_cnt <= bit_cnt + 1'b1;
                end else if (bit_cnt == LAST_BIT) begin
                    bit_cnt <= ACK_BIT;
                    if (state == ST_RD) begin
                        next_st <= sda_lvl ? ST_SKIP : ST_RD;
                    end
                    if ((state == ST_GC) && gc_hit) begin
                        soft_rst <= 1'b1;
                    end
                end
            end else if (active && scl_fall) begin
                if (bit_cnt == LAST_BIT) begin
                    case (state)
                        ST_ADDR: begin
                            if (own_match) begin
                                sda_pull <= 1'b1;
                                next_st  <= rx_sh[0] ? ST_RD : ST_WR;
                            end else if (rx_sh == GC_ADDR_BYTE) begin
                                sda_pull <= 1'b1;
                                next_st  <= ST_GC;
                            end else begin
                                sda_pull <= 1'b0;
                                next_st  <= ST_SKIP;
                            end
                        end
                        ST_WR: begin
                            sda_pull <= 1'b1;
                            next_st  <= ST_WR;
                            if (!ptr_valid) begin
                                ptr       <= rx_sh;
                                ptr_valid <= 1'b1;
                            end else begin
                                reg_wr    <= 1'b1;
                                reg_wdata <= rx_sh;
                                wr_done   <= 1'b1;
                            end
                        end
                        ST_GC: begin
                            gc_hit   <= (rx_sh == GC_RST_CMD);
                            sda_pull <= (rx_sh == GC_RST_CMD);
                            next_st  <= ST_SKIP;
                        end
                        default: begin
                            sda_pull <= 1'b0;
                        end
                    endcase
                end else if (bit_cnt == ACK_BIT) begin
                    bit_cnt  <= '0;
                    state    <= next_st;
                    sda_pull <= 1'b0;
                    wr_done  <= 1'b0;
                    if (load_rd) begin
                        tx_sh    <= {reg_rdata[BYTE_W-2:0], 1'b0};
                        sda_pull <= ~reg_rdata[BYTE_W-1];
                        ptr      <= ptr + 1'b1;
                    end else if (wr_done) begin
                        ptr <= ptr + 1'b1;
                    end
                end else if ((state == ST_RD) && (bit_cnt != '0)) begin
                    sda_pull <= ~tx_sh[BYTE_W-1];
                    tx_sh    <= {tx_sh[BYTE_W-2:0], 1'b0};
                end
            end
        end
    end
endmodule

// File: rtl/i2c_target_gcr.sv
`timescale 1ns/1ps
// Top: two-wire bus target with register port and general-call reset.
// Assumes clk runs at least 16x the bus bit rate; the pad driver turns
// sda_pull_o into an open-drain low.
module i2c_target_gcr
    import i2c_tgt_pkg::*;
#(
    parameter logic [5:0] ADDR_PREFIX = 6'b100110,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic              addr_pin_i,
    output logic              sda_pull_o,
    output logic              reg_wr_o,
    output logic              reg_rd_o,
    output logic [BYTE_W-1:0] reg_addr_o,
    output logic [BYTE_W-1:0] reg_wdata_o,
    input  logic [BYTE_W-1:0] reg_rdata_i,
    output logic              soft_rst_o
);
    logic [1:0] lvl, rise, fall;
    logic       scl_lvl, scl_rise, scl_fall, sda_lvl;
    logic       start_det, stop_det;

    i2c_tgt_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  ({sda_i, scl_i}),
        .lvl_o  (lvl),
        .rise_o (rise),
        .fall_o (fall)
    );

    assign scl_lvl  = lvl[0];
    assign scl_rise = rise[0];
    assign scl_fall = fall[0];
    assign sda_lvl  = lvl[1];

    i2c_tgt_cond u_cond (
        .scl_lvl  (scl_lvl),
        .sda_rise (rise[1]),
        .sda_fall (fall[1]),
        .start_o  (start_det),
        .stop_o   (stop_det)
    );

    i2c_tgt_engine #(.ADDR_PREFIX(ADDR_PREFIX)) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .sda_lvl   (sda_lvl),
        .start_det (start_det),
        .stop_det  (stop_det),
        .addr_pin  (addr_pin_i),
        .reg_rdata (reg_rdata_i),
        .sda_pull  (sda_pull_o),
        .reg_wr    (reg_wr_o),
        .reg_rd    (reg_rd_o),
        .reg_addr  (reg_addr_o),
        .reg_wdata (reg_wdata_o),
        .soft_rst  (soft_rst_o)
    );
endmodule

// File: rtl/i2c_target_gcr_chk.sv
`timescale 1ns/1ps
// Checker: protocol properties of the bus target, bound to the top.
module i2c_target_gcr_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_lvl,
    input logic scl_rise,
    input logic stop_det,
    input logic sda_pull_o,
    input logic reg_wr_o,
    input logic reg_rd_o,
    input logic soft_rst_o
);
    AST_PULL_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n) !$stable(sda_pull_o) |-> !$past(scl_lvl)); // R8
    AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) stop_det |=> !sda_pull_o); // R8
    AST_RST_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n) $rose(soft_rst_o) |-> $past(scl_rise)); // R6
    AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) soft_rst_o |=> !soft_rst_o); // R6
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(reg_wr_o && reg_rd_o)); // R3
    AST_FETCH_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n) reg_rd_o |-> !scl_lvl); // R4
endmodule

bind i2c_target_gcr i2c_target_gcr_chk u_chk (.*);

// File: tb/i2c_target_gcr_tb_top.sv
`timescale 1ns/1ps
module i2c_target_gcr_tb_top;
    localparam logic [5:0] PFX = 6'b100110;
    localparam int Q = 8;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n = 1'b0;
    logic scl_drv = 1'b1, sda_drv = 1'b1, a0 = 1'b1;
    logic sda_pull, reg_wr, reg_rd, soft_rst, sda_line;
    logic [7:0] reg_addr, reg_wdata, reg_rdata;

    assign sda_line  = sda_drv & ~sda_pull;
    assign reg_rdata = reg_addr ^ 8'h5A;

    i2c_target_gcr #(.ADDR_PREFIX(PFX)) dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_drv), .sda_i(sda_line),
        .addr_pin_i(a0), .sda_pull_o(sda_pull), .reg_wr_o(reg_wr),
        .reg_rd_o(reg_rd), .reg_addr_o(reg_addr), .reg_wdata_o(reg_wdata),
        .reg_rdata_i(reg_rdata), .soft_rst_o(soft_rst)
    );

    int n_tests = 0, n_fail = 0;
    int cyc = 0, ack_rise_cyc = 0, rst_cyc = 0, rst_cnt = 0, rst_hi = 0, rd_cnt = 0;
    logic [15:0] exp_q[$];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    // Monitor: scoreboard for writes, counters for fetches and resets.
    always @(negedge clk) begin
        if (rst_n) begin
            if (reg_wr) begin
                if (exp_q.size() == 0) check("R3 unexpected write", {reg_addr, reg_wdata}, 16'hFFFF);
                else check("R3 write addr/data", {reg_addr, reg_wdata}, exp_q.pop_front());
            end
            if (reg_rd) rd_cnt++;
            if (soft_rst) begin
                rst_hi++;
                rst_cyc = cyc;
            end
        end
    end

    logic soft_rst_d = 1'b0;
    always @(negedge clk) begin
        if (soft_rst && !soft_rst_d) rst_cnt++;
        soft_rst_d <= soft_rst;
    end

    task automatic wq(); repeat (Q) @(negedge clk); endtask
    task automatic bus_start();
        sda_drv = 1; wq(); scl_drv = 1; wq(); sda_drv = 0; wq(); scl_drv = 0; wq();
    endtask
    task automatic bus_stop();
        sda_drv = 0; wq(); scl_drv = 1; wq(); sda_drv = 1; wq();
    endtask
    task automatic send_bit(input logic b);
        sda_drv = b; wq(); scl_drv = 1; wq(); wq(); scl_drv = 0; wq();
    endtask
    task automatic recv_bit(output logic b);
        sda_drv = 1; wq(); scl_drv = 1; ack_rise_cyc = cyc; wq();
        b = sda_line; wq(); scl_drv = 0; wq();
    endtask
    task automatic write_byte(input logic [7:0] d, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) send_bit(d[i]);
        recv_bit(b);
        ack = ~b;
    endtask
    task automatic read_byte(input logic master_ack, output logic [7:0] d);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(b);
            d[i] = b;
        end
        send_bit(~master_ack);
    endtask

    initial begin
        logic ack, b;
        logic [7:0] d;
        int r0, rd0;
        repeat (5) @(negedge clk);
        check("R1 reset outputs", {sda_pull, reg_wr, reg_rd, soft_rst}, 4'b0000);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R1 after reset release", {sda_pull, reg_wr, reg_rd, soft_rst}, 4'b0000);

        // R2/R3: write with A0 = 1, pointer 0x10, two data bytes
        exp_q.push_back(16'h10A5);
        exp_q.push_back(16'h113C);
        bus_start();
        write_byte({PFX, 1'b1, 1'b0}, ack); check("R2 own address ack", ack, 1);
        write_byte(8'h10, ack); check("R3 pointer byte ack", ack, 1);
        write_byte(8'hA5, ack); check("R3 data byte ack", ack, 1);
        write_byte(8'h3C, ack); check("R3 second data ack", ack, 1);
        bus_stop();
        wq();
        check("R8 released after stop", sda_pull, 0);
        check("R3 writes consumed", exp_q.size(), 0);

        // R2: mismatching address (pin is 1, address LSB 0), data ignored
        bus_start();
        write_byte({PFX, 1'b0, 1'b0}, ack); check("R2 mismatch nack", ack, 0);
        write_byte(8'h55, ack); check("R2 ignored byte nack", ack, 0);
        write_byte(8'h66, ack); check("R2 ignored byte2 nack", ack, 0);
        bus_stop();

        // R2: ten-bit header byte refused
        bus_start();
        write_byte(8'hF0, ack); check("R2 ten-bit header nack", ack, 0);
        bus_stop();

        // R2: pin selects the LSB
        a0 = 1'b0;
        exp_q.push_back(16'h4099);
        bus_start();
        write_byte({PFX, 1'b0, 1'b0}, ack); check("R2 pin=0 address ack", ack, 1);
        write_byte(8'h40, ack);
        write_byte(8'h99, ack); check("R3 data ack pin=0", ack, 1);
        bus_stop();
        check("R3 pin=0 write consumed", exp_q.size(), 0);

        // R7/R4/R5: set pointer, repeated start, read two bytes
        rd0 = rd_cnt;
        bus_start();
        write_byte({PFX, 1'b0, 1'b0}, ack);
        write_byte(8'h20, ack); check("R7 pointer before restart", ack, 1);
        bus_start();
        write_byte({PFX, 1'b0, 1'b1}, ack); check("R7 read address after restart", ack, 1);
        read_byte(1'b1, d); check("R4 first read byte", d, 8'h20 ^ 8'h5A);
        read_byte(1'b0, d); check("R4 second read byte", d, 8'h21 ^ 8'h5A);
        recv_bit(b); check("R5 released after nack", b, 1);
        recv_bit(b); check("R5 still released", b, 1);
        bus_stop();
        check("R4 fetch strobes", rd_cnt - rd0, 2);

        // R6: general call with reset command
        r0 = rst_cnt;
        bus_start();
        write_byte(8'h00, ack); check("R6 general call ack", ack, 1);
        check("R6 no reset yet", rst_cnt, r0);
        write_byte(8'h06, ack); check("R6 reset command ack", ack, 1);
        check("R6 one reset pulse", rst_cnt, r0 + 1);
        check("R6 reset at ack rise", rst_cyc - ack_rise_cyc, 3);
        check("R6 pulse width", rst_hi, 1);
        bus_stop();

        // R6: other command byte
        r0 = rst_cnt;
        bus_start();
        write_byte(8'h00, ack);
        write_byte(8'h04, ack); check("R6 other command nack", ack, 0);
        bus_stop();
        wq();
        check("R6 no reset for other command", rst_cnt, r0);
        check("R3 no stray writes", exp_q.size(), 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog (all requirements) act=timeout exp=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule